// File: doc/BRIEF.md
# Masked Packed Float-to-Unsigned-64 Conversion Unit

This unit turns a vector of single-precision floating-point elements into a vector of unsigned 64-bit integers, one element per lane, and merges the result into a prior destination value. Each source element is 32 bits wide and each result is 64 bits, so a 256-bit source fills a 512-bit destination. A vector-length code chooses how many lanes take part. Every destination bit above that length is cleared.

A per-lane mask decides which lanes receive a conversion. A lane that is masked off either keeps its prior destination value or is written with zero, depending on a merge/zero select. A memory-sourced operation with the broadcast bit set feeds element 0 to every lane. A register-sourced operation at full length with the same bit set swaps in an embedded rounding mode for the global one. A reserved 4-bit specifier field that is not all ones, or an unused vector-length code, raises a fault. In that case the destination passes through unchanged.

An operation is presented for one cycle on `opValid`. Its result, with the OR-reduced invalid and inexact flags and the fault, is registered and appears one cycle later with `resValid`. Memory access and the decode of other instruction fields are done elsewhere.

Top module: `packed_cvt_unit`

## Requirements
- R1: Vector-length code 0, 1 and 2 activates 2, 4 and 8 lanes. Lane j reads source bits [32j+31:32j] and writes destination bits [64j+63:64j].
- R2: A converted lane holds the source value rounded to an unsigned integer by the selected rounding mode. The mode encoding is 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. The lane's inexact flag is set when the value was not already an integer.
- R3: NaN, infinity, a value that rounds to 2^64 or more, and a negative value that rounds to a nonzero magnitude each make the lane all ones with its invalid flag set and its inexact flag clear. A negative value that rounds to zero gives 0 and is inexact.
- R4: A lane converts when its mask bit is 1 or `maskOff` is 1. Otherwise, with `zeroMode` 0 the lane keeps its prior destination value, and with `zeroMode` 1 it is written with 0.
- R5: All destination bits at or above the active length, up to bit 511, are 0.
- R6: With `memSrc` and `bcast` both 1, every converting lane uses source element 0.
- R7: The embedded rounding mode applies only when `memSrc` is 0, the length code is 2 and `bcast` is 1. Every other operation uses the global mode, and a register source with `bcast` set performs no broadcast.
- R8: When `resvSpec` is not 4'b1111, or the length code is 3, `faultOut` is 1, the destination equals the prior destination, and both flags are 0.
- R9: `invalidOut` and `inexactOut` are the OR of the flags of converted lanes only. A lane that is masked off or inactive contributes nothing, even when its source is NaN.
- R10: After reset `resValid`, `destOut`, the flags and `faultOut` are 0. The result of an operation accepted on `opValid` appears on the next cycle with `resValid` 1, and back-to-back operations yield back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation presented this cycle |
| srcVec | input | 256 | Eight single-precision source elements |
| priorDest | input | 512 | Previous destination value |
| laneMask | input | 8 | Per-lane write mask |
| maskOff | input | 1 | Treat every lane as selected |
| zeroMode | input | 1 | 0 keeps old lanes, 1 zeroes them |
| vlSel | input | 2 | Length code: 0 = 128, 1 = 256, 2 = 512 bits |
| bcast | input | 1 | Broadcast / rounding-override bit |
| memSrc | input | 1 | Source came from memory |
| embRound | input | 2 | Embedded rounding mode |
| globRound | input | 2 | Global rounding mode |
| resvSpec | input | 4 | Reserved specifier, must be 4'b1111 |
| resValid | output | 1 | Result valid |
| destOut | output | 512 | Converted destination |
| invalidOut | output | 1 | OR of invalid flags of converted lanes |
| inexactOut | output | 1 | OR of inexact flags of converted lanes |
| faultOut | output | 1 | Undefined-encoding fault |

## Verification
The bench builds the unit with its default of eight lanes. This makes all three legal length codes reachable, along with the unused fourth code that must fault, and lets broadcast and the rounding override be tried at full width. At that width, lanes can be given saturating inputs (NaN, infinity, 2^64, negative) side by side with exact and tie values, and masked-off NaN lanes can be set beside clean ones to show that their flags stay out of the reduction.

// File: rtl/pcvt_pkg.sv
`timescale 1ns/1ps
package pcvt_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned SRC_EW = 32;
  localparam int unsigned DST_EW = 64;
  localparam int unsigned SRC_W  = LANES * SRC_EW;
  localparam int unsigned DST_W  = LANES * DST_EW;

  typedef enum logic [1:0] {
    RND_NEAR  = 2'd0,
    RND_DOWN  = 2'd1,
    RND_UP    = 2'd2,
    RND_TRUNC = 2'd3
  } rmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic             fault;
    logic             bcastSel;
    rmode_e           rmode;
    logic [LANES-1:0] laneConv;
    logic [LANES-1:0] laneKeep;
  } lane_ctl_t;
endpackage

// File: rtl/f32_u64_lane.sv
`timescale 1ns/1ps
module f32_u64_lane import pcvt_pkg::*; (
  input  logic [SRC_EW-1:0] fpIn,
  input  rmode_e            rmode,
  output logic [DST_EW-1:0] intOut,
  output logic              invalid,
  output logic              inexact
);
  localparam int unsigned FracW    = 23;
  localparam int unsigned ExpW     = 8;
  localparam int unsigned Bias     = 127;
  localparam int unsigned SigW     = FracW + 1;
  localparam int unsigned PointPos = Bias + FracW;   // exponent of unit LSB
  localparam int unsigned OvfExp   = Bias + DST_EW;  // first exponent past range
  localparam int unsigned GuardW   = SigW + 2;
  localparam int unsigned WideW    = SigW + GuardW;

  logic              neg;
  logic [ExpW-1:0]   expRaw;
  logic [ExpW-1:0]   expEff;
  logic [SigW-1:0]   sig;
  logic              isSpecial;
  logic              bigPath;
  logic              ovf;
  logic [ExpW-1:0]   lsh;
  logic [ExpW-1:0]   rsh;
  logic [ExpW-1:0]   rshCap;
  logic [WideW-1:0]  wide;
  logic [SigW-1:0]   intPart;
  logic              rndBit;
  logic              stkBit;
  logic              incr;
  logic [DST_EW-1:0] magSmall;
  logic [DST_EW-1:0] magBig;
  logic [DST_EW-1:0] mag;

  always_comb begin
    neg       = fpIn[SRC_EW-1];
    expRaw    = fpIn[SRC_EW-2 -: ExpW];
    expEff    = (expRaw == '0) ? ExpW'(1) : expRaw;
    sig       = {expRaw != '0, fpIn[FracW-1:0]};
    isSpecial = (expRaw == '1);
    bigPath   = (expEff >= ExpW'(PointPos));
    ovf       = bigPath && (expEff >= ExpW'(OvfExp));
    lsh       = expEff - ExpW'(PointPos);
    rsh       = ExpW'(PointPos) - expEff;
    // shifting past the guard field only moves bits into sticky
    rshCap    = (rsh > ExpW'(GuardW)) ? ExpW'(GuardW) : rsh;
    wide      = {sig, {GuardW{1'b0}}} >> rshCap;
    intPart   = wide[WideW-1 -: SigW];
    rndBit    = wide[GuardW-1];
    stkBit    = |wide[GuardW-2:0];
    unique case (rmode)
      RND_NEAR:  incr = rndBit & (stkBit | intPart[0]);
      RND_DOWN:  incr = neg & (rndBit | stkBit);
      RND_UP:    incr = ~neg & (rndBit | stkBit);
      default:   incr = 1'b0;
    endcase
    magSmall  = DST_EW'(intPart) + DST_EW'(incr);
    magBig    = DST_EW'(sig) << lsh;
    mag       = bigPath ? magBig : magSmall;
    invalid   = isSpecial || ovf || (neg && (mag != '0));
    inexact   = !invalid && !bigPath && (rndBit | stkBit);
    intOut    = invalid ? '1 : (neg ? '0 : mag);
  end
endmodule

// File: rtl/pcvt_ctrl.sv
`timescale 1ns/1ps
module pcvt_ctrl import pcvt_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskOff,
  input  logic             zeroMode,
  input  logic [1:0]       vlSel,
  input  logic             bcast,
  input  logic             memSrc,
  input  logic [1:0]       embRound,
  input  logic [1:0]       globRound,
  input  logic [3:0]       resvSpec,
  output lane_ctl_t        ctl
);
  localparam int unsigned WideCode = $clog2(LANES) - 1;
  localparam int unsigned HalfLanes = LANES / 2;

  logic        vlLegal;
  logic        fault;
  logic        useEmb;
  int unsigned activeLanes;

  always_comb begin
    vlLegal     = ((HalfLanes >> vlSel) != 0);
    fault       = (resvSpec != 4'hF) || !vlLegal;
    activeLanes = 32'd2 << vlSel;
    useEmb      = !memSrc && bcast && (32'(vlSel) == WideCode);

    ctl.capture  = opValid;
    ctl.fault    = fault;
    ctl.bcastSel = memSrc && bcast;
    ctl.rmode    = rmode_e'(useEmb ? embRound : globRound);
    for (int j = 0; j < LANES; j++) begin
      ctl.laneConv[j] = !fault && (j < activeLanes) && (maskOff || laneMask[j]);
      ctl.laneKeep[j] = fault ||
                        ((j < activeLanes) && !(maskOff || laneMask[j]) && !zeroMode);
    end
  end

  // R7: global mode whenever the override conditions are not all met
  a_r7_global_round: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (memSrc || !bcast) |-> (2'(ctl.rmode) == globRound));

  // R8: a bad specifier field stops every lane from converting
  a_r8_fault_no_conv: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (resvSpec != 4'hF) |-> ctl.fault && (ctl.laneConv == '0));

  // R1: shortest length leaves the upper lanes unconverted
  a_r1_short_lanes: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (vlSel == 2'd0) |-> (ctl.laneConv[LANES-1:2] == '0));
endmodule

// File: rtl/pcvt_datapath.sv
`timescale 1ns/1ps
module pcvt_datapath import pcvt_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  lane_ctl_t        ctl,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [DST_W-1:0] priorDest,
  output logic             resValid,
  output logic [DST_W-1:0] destOut,
  output logic             invalidOut,
  output logic             inexactOut,
  output logic             faultOut
);
  logic [LANES-1:0] laneInv;
  logic [LANES-1:0] laneInx;
  logic [DST_W-1:0] destNext;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SRC_EW-1:0] elem;
    logic [DST_EW-1:0] cvt;

    assign elem = ctl.bcastSel ? srcVec[SRC_EW-1:0] : srcVec[j*SRC_EW +: SRC_EW];

    f32_u64_lane u_cvt (
      .fpIn    (elem),
      .rmode   (ctl.rmode),
      .intOut  (cvt),
      .invalid (laneInv[j]),
      .inexact (laneInx[j])
    );

    assign destNext[j*DST_EW +: DST_EW] =
      ctl.laneConv[j] ? cvt :
      ctl.laneKeep[j] ? priorDest[j*DST_EW +: DST_EW] : '0;

    // R4: a lane neither converted nor kept reads back zero
    a_r4_zero_lane: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture && !ctl.laneConv[j] && !ctl.laneKeep[j]
      |=> (destOut[j*DST_EW +: DST_EW] == '0));

    // R4: a kept lane carries the prior destination through
    a_r4_keep_lane: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture && ctl.laneKeep[j]
      |=> (destOut[j*DST_EW +: DST_EW] == $past(priorDest[j*DST_EW +: DST_EW])));

    // R3: NaN or infinity saturates and flags invalid
    a_r3_special_sat: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture && ctl.laneConv[j] && (elem[SRC_EW-2 -: 8] == 8'hFF)
      |=> (destOut[j*DST_EW +: DST_EW] == '1) && invalidOut);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      destOut    <= '0;
      invalidOut <= 1'b0;
      inexactOut <= 1'b0;
      faultOut   <= 1'b0;
    end else begin
      resValid <= ctl.capture;
      if (ctl.capture) begin
        destOut    <= destNext;
        invalidOut <= |(laneInv & ctl.laneConv);
        inexactOut <= |(laneInx & ctl.laneConv);
        faultOut   <= ctl.fault;
      end
    end
  end

  // R9: no converted lane means no flags
  a_r9_quiet_flags: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && (ctl.laneConv == '0) |=> !invalidOut && !inexactOut);

  // R10: one-cycle result latency
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> resValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> !resValid);
endmodule

// File: rtl/packed_cvt_unit.sv
`timescale 1ns/1ps
module packed_cvt_unit import pcvt_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [DST_W-1:0] priorDest,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskOff,
  input  logic             zeroMode,
  input  logic [1:0]       vlSel,
  input  logic             bcast,
  input  logic             memSrc,
  input  logic [1:0]       embRound,
  input  logic [1:0]       globRound,
  input  logic [3:0]       resvSpec,
  output logic             resValid,
  output logic [DST_W-1:0] destOut,
  output logic             invalidOut,
  output logic             inexactOut,
  output logic             faultOut
);
  localparam int unsigned ShortW = 2 * DST_EW;

  lane_ctl_t ctl;

  pcvt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .laneMask  (laneMask),
    .maskOff   (maskOff),
    .zeroMode  (zeroMode),
    .vlSel     (vlSel),
    .bcast     (bcast),
    .memSrc    (memSrc),
    .embRound  (embRound),
    .globRound (globRound),
    .resvSpec  (resvSpec),
    .ctl       (ctl)
  );

  pcvt_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .srcVec     (srcVec),
    .priorDest  (priorDest),
    .resValid   (resValid),
    .destOut    (destOut),
    .invalidOut (invalidOut),
    .inexactOut (inexactOut),
    .faultOut   (faultOut)
  );

  // R5: shortest length clears everything above the first two lanes
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (vlSel == 2'd0) && (resvSpec == 4'hF)
    |=> (destOut[DST_W-1:ShortW] == '0));

  // R8: fault passes the prior destination through with no flags
  a_r8_fault_pass: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (resvSpec != 4'hF)
    |=> faultOut && (destOut == $past(priorDest)) && !invalidOut && !inexactOut);
endmodule

// File: tb/tb_packed_cvt_unit.sv
`timescale 1ns/1ps
module tb_packed_cvt_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [255:0] srcVec = '0;
  logic [511:0] priorDest = '0;
  logic [7:0]   laneMask = '0;
  logic         maskOff = 1'b0;
  logic         zeroMode = 1'b0;
  logic [1:0]   vlSel = '0;
  logic         bcast = 1'b0;
  logic         memSrc = 1'b0;
  logic [1:0]   embRound = '0;
  logic [1:0]   globRound = '0;
  logic [3:0]   resvSpec = 4'hF;
  logic         resValid;
  logic [511:0] destOut;
  logic         invalidOut;
  logic         inexactOut;
  logic         faultOut;

  packed_cvt_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .srcVec(srcVec),
    .priorDest(priorDest), .laneMask(laneMask), .maskOff(maskOff),
    .zeroMode(zeroMode), .vlSel(vlSel), .bcast(bcast), .memSrc(memSrc),
    .embRound(embRound), .globRound(globRound), .resvSpec(resvSpec),
    .resValid(resValid), .destOut(destOut), .invalidOut(invalidOut),
    .inexactOut(inexactOut), .faultOut(faultOut)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [511:0] dest;
    logic         inv;
    logic         inx;
    logic         flt;
    string        tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;

  // operation under construction
  logic [255:0] tSrc;
  logic [511:0] tPrior;
  logic [7:0]   tMask;
  logic         tMaskOff, tZero, tBc, tMem;
  logic [1:0]   tVl, tEmb, tGlob;
  logic [3:0]   tResv;

  function automatic void refLane(input logic [31:0] x, input logic [1:0] rm,
                                  output logic [63:0] r, output logic inv,
                                  output logic inx);
    logic        s;
    logic [7:0]  e;
    logic [63:0] m, q, rem, half;
    logic        up;
    int          ex;
    s = x[31];
    e = x[30:23];
    m = (e == 0) ? {41'd0, x[22:0]} : {40'd0, 1'b1, x[22:0]};
    ex = (e == 0) ? -149 : int'(e) - 150;
    inv = 0; inx = 0; up = 0; q = 0; rem = 0; half = 0;
    if (e == 8'hFF) inv = 1;
    else if (ex >= 0) begin
      if (ex > 40) inv = 1;
      else q = m << ex;
    end else begin
      if (-ex >= 40) begin
        q = 0; rem = m; half = 64'd1 << 39;
      end else begin
        q = m >> (-ex);
        rem = m - (q << (-ex));
        half = 64'd1 << (-ex - 1);
      end
      if (rem != 0) begin
        inx = 1;
        case (rm)
          2'd0: up = (rem > half) || ((rem == half) && q[0]);
          2'd1: up = s;
          2'd2: up = !s;
          default: up = 0;
        endcase
      end
      q = q + 64'(up);
    end
    if (!inv && s && (q != 0)) inv = 1;
    if (inv) begin r = '1; inx = 0; end
    else r = s ? 64'd0 : q;
  endfunction

  function automatic exp_t model(string tag);
    exp_t        o;
    int          n;
    logic [1:0]  rm;
    logic [31:0] el;
    logic [63:0] r;
    logic        li, lx;
    o.tag = tag; o.inv = 0; o.inx = 0; o.dest = '0;
    o.flt = (tResv != 4'hF) || (tVl == 2'd3);
    if (o.flt) begin
      o.dest = tPrior;
      return o;
    end
    n  = (tVl == 0) ? 2 : (tVl == 1) ? 4 : 8;
    rm = (!tMem && (tVl == 2) && tBc) ? tEmb : tGlob;
    for (int j = 0; j < 8; j++) begin
      if (j >= n) o.dest[j*64 +: 64] = '0;
      else if (tMaskOff || tMask[j]) begin
        el = (tMem && tBc) ? tSrc[31:0] : tSrc[j*32 +: 32];
        refLane(el, rm, r, li, lx);
        o.dest[j*64 +: 64] = r;
        o.inv |= li;
        o.inx |= lx;
      end else
        o.dest[j*64 +: 64] = tZero ? 64'd0 : tPrior[j*64 +: 64];
    end
    return o;
  endfunction

  task automatic defaults();
    tSrc = '0; tPrior = '0; tMask = '0; tMaskOff = 1; tZero = 0;
    tBc = 0; tMem = 0; tVl = 2'd2; tEmb = 0; tGlob = 0; tResv = 4'hF;
  endtask

  task automatic fire(string tag);
    @(negedge clk);
    srcVec = tSrc; priorDest = tPrior; laneMask = tMask; maskOff = tMaskOff;
    zeroMode = tZero; vlSel = tVl; bcast = tBc; memSrc = tMem;
    embRound = tEmb; globRound = tGlob; resvSpec = tResv;
    opValid = 1'b1;
    expQ.push_back(model(tag));
  endtask

  task automatic idle(int cyc);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      opValid = 1'b0;
    end
  endtask

  // monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    exp_t e;
    if (rstN && resValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result dest=%h", destOut);
      end else begin
        e = expQ.pop_front();
        if (destOut !== e.dest || invalidOut !== e.inv ||
            inexactOut !== e.inx || faultOut !== e.flt) begin
          errors++;
          $display("FAIL %s dest=%h exp=%h inv=%b/%b inx=%b/%b fault=%b/%b",
                   e.tag, destOut, e.dest, invalidOut, e.inv,
                   inexactOut, e.inx, faultOut, e.flt);
        end
      end
    end
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (resValid !== 0 || destOut !== '0 || invalidOut !== 0 ||
        inexactOut !== 0 || faultOut !== 0) begin
      errors++;
      $display("FAIL R10 reset state act=%b%b%b%b exp=0000", resValid,
               invalidOut, inexactOut, faultOut);
    end

    // R2: nearest-even on exact, tie and small values
    defaults();
    tSrc = {32'h3E800000, 32'h42F60000, 32'h53800000, 32'h3FC00000,
            32'h00000000, 32'h40600000, 32'h40200000, 32'h3F800000};
    fire("R2 nearest");
    // R2: the other three modes on the same data
    tGlob = 2'd1; fire("R2 down");
    tGlob = 2'd2; fire("R2 up");
    tGlob = 2'd3; fire("R2 trunc");
    idle(2);

    // R3: NaN, inf, 2^64, -1, -0.25, 2^63, max, denormal
    defaults();
    tSrc = {32'h00000001, 32'h5F7FFFFF, 32'h5F000000, 32'hBE800000,
            32'hBF800000, 32'h5F800000, 32'h7F800000, 32'h7FC00000};
    fire("R3 specials");
    tGlob = 2'd1; fire("R3 negative rounds down");
    tGlob = 2'd2; fire("R3 denormal up");
    idle(2);

    // R9: only exact lanes give no flags
    defaults();
    for (int j = 0; j < 8; j++) tSrc[j*32 +: 32] = 32'h3F800000 + 32'(j << 23);
    fire("R9 exact no flags");
    idle(1);

    // R4: merge and zero masking at 256 bits
    defaults();
    tVl = 2'd1; tMaskOff = 0; tMask = 8'b1111_0101;
    tPrior = {8{64'hA5A5_5A5A_0F0F_F0F0}};
    tSrc = {32'h7FC00000, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000,
            32'h40A00000, 32'h40400000, 32'h40000000, 32'h3F800000};
    fire("R4 merge");
    tZero = 1; fire("R4 zero");
    idle(1);

    // R9: masked-off NaN lanes stay out of the flags
    defaults();
    tMaskOff = 0; tMask = 8'b0101_0101;
    tSrc = {32'h7FC00000, 32'h40400000, 32'hFF800000, 32'h40000000,
            32'h7FC00000, 32'h41200000, 32'hBF800000, 32'h3F800000};
    fire("R9 masked NaN");
    idle(1);

    // R5: 128-bit length clears the upper six lanes
    defaults();
    tVl = 2'd0; tPrior = '1;
    tSrc = {8{32'h40E00000}};
    fire("R5 upper clear");
    // R1: 256-bit length lane mapping
    tVl = 2'd1;
    tSrc = {32'h41000000, 32'h40E00000, 32'h40C00000, 32'h40A00000,
            32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000};
    fire("R1 lane map");
    idle(1);

    // R6: memory broadcast of element 0
    defaults();
    tMem = 1; tBc = 1;
    tSrc = {32'h7FC00000, 32'h41000000, 32'h40E00000, 32'h40C00000,
            32'h40A00000, 32'h40800000, 32'h7F800000, 32'h40400000};
    fire("R6 broadcast full");
    tVl = 2'd1; tMaskOff = 0; tMask = 8'b0000_0110; tZero = 1;
    fire("R6 broadcast masked");
    idle(1);

    // R7: embedded rounding override and where it is ignored
    defaults();
    tBc = 1; tEmb = 2'd2; tGlob = 2'd0;
    tSrc = {8{32'h40200000}};
    fire("R7 override used");
    tVl = 2'd1; fire("R7 short length ignores override");
    tVl = 2'd2; tMem = 1; fire("R7 memory ignores override");
    idle(1);

    // R8: reserved field and unused length code
    defaults();
    tPrior = {8{64'h0123_4567_89AB_CDEF}};
    tSrc = {8{32'h7FC00000}};
    tResv = 4'hE; fire("R8 reserved field");
    tResv = 4'hF; tVl = 2'd3; fire("R8 unused length");
    idle(1);

    // R10: back-to-back results
    defaults();
    tSrc = {8{32'h40400000}}; fire("R10 burst a");
    tSrc = {8{32'h3F000000}}; fire("R10 burst b");
    tSrc = {8{32'h3FC00000}}; tGlob = 2'd3; fire("R10 burst c");
    idle(4);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10 results missing act=%0d exp=0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule